// File: doc/BRIEF.md
# Misaligned Bus Transfer Sequencer

The sequencer takes one data-transfer request from a processor core and turns it into one or more cycles on a 64-bit data bus with active-high byte enables. A request names a byte address, a size of 1, 2, 4 or 8 bytes, a kind (memory read, memory write, I/O read, I/O write), a lock flag and a flag for a locked 8-byte compare-exchange. When the bytes of the request fit inside the boundary that applies to its size, one bus cycle is run. When they do not, the request is cut at the boundary into a low piece and a high piece. Each piece becomes its own bus cycle, and the bus cycles are run in an order that depends on the kind of transfer.

On the request side, a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a core that holds `req_valid` high simply waits. The request fields must stay steady while `req_valid` is high.

On the bus side, each cycle is offered with `bus_valid` together with a quadword address, the byte enables and the cycle attributes. The bus returns `bus_done` to finish that cycle, and until then all bus outputs hold still. Write bytes are steered to the lanes that match their addresses. Read bytes are gathered from those lanes into a right-justified result. When the final bus cycle completes, the result is returned on a one-cycle `rsp_valid` pulse. The response side cannot apply back-pressure.

Top module: `xfer_splitter`

## Requirements
- R1: A 1-byte transfer runs as one cycle. A 2- or 4-byte transfer runs as one cycle when all of its bytes lie in one 4-byte-aligned range. This includes a 2-byte transfer at an offset of 1 within the range.
- R2: An 8-byte transfer runs as one cycle only when all of its bytes lie in one 8-byte-aligned range. Any transfer that crosses its boundary runs as exactly two cycles.
- R3: The low piece covers the bytes from the start address up to the boundary, and the high piece covers the rest. In each cycle, `bus_addr` is the piece's address with the low 3 bits cleared. Bit k of `bus_be` is 1 exactly when the piece holds the byte whose address ends in k.
- R4: A split memory read, memory write or I/O read runs the low piece first. A split I/O write runs the high piece first. The kind is encoded on `req_kind` as 00 memory read, 01 memory write, 10 I/O read and 11 I/O write, so bit 0 selects write and bit 1 selects I/O.
- R5: `bus_lock` is high in every cycle of a locked request. `bus_scyc` is high in every cycle exactly when the request is locked and split, and is low otherwise.
- R6: When `req_cmpx` is set, the request is a memory operation of 8 bytes, whatever `req_size` and `req_kind` say, and it is locked. When aligned, it runs one read and then one write. When misaligned, it runs reads of the low, high, low and high pieces, then writes of the low, high, low and high pieces, for eight cycles in all.
- R7: Byte i of `req_wdata` belongs at address `req_addr`+i. It is driven on lane (`req_addr`+i) mod 8 of `bus_wdata` in the write cycle that carries that byte.
- R8: `rsp_valid` pulses for one cycle, on the cycle after the final `bus_done`. `rsp_rdata` then holds the bytes read, right-justified, with all bytes above the size set to zero. A request with no read cycles returns zero. A compare-exchange returns the bytes of its last read pair.
- R9: `req_ready` is low whenever `bus_valid` is high. While `bus_valid` is high and `bus_done` is low, the bus outputs do not change.
- R10: After reset, `req_ready` is high, and `bus_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Byte address of the transfer |
| req_size | input | 2 | Size code: 0,1,2,3 for 1,2,4,8 bytes |
| req_kind | input | 2 | Transfer kind, encoded as in R4 |
| req_lock | input | 1 | Run the sequence locked |
| req_cmpx | input | 1 | Locked 8-byte compare-exchange |
| req_wdata | input | DW | Right-justified write data |
| bus_valid | output | 1 | Bus cycle offered |
| bus_done | input | 1 | Bus cycle finished this clock |
| bus_addr | output | AW | Quadword address of the cycle |
| bus_be | output | DW/8 | Byte enables, active high |
| bus_write | output | 1 | Cycle is a write |
| bus_io | output | 1 | Cycle is in I/O space |
| bus_lock | output | 1 | Locked cycle |
| bus_scyc | output | 1 | Locked split sequence marker |
| bus_wdata | output | DW | Lane-steered write data |
| bus_rdata | input | DW | Read data, sampled when `bus_done` is high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Merged right-justified read data |

## Verification
The assertions assume that the bus raises `bus_done` only while `bus_valid` is high, and that `bus_rdata` is meaningful only on that clock. The bench keeps to this by driving `bus_done` only after it has seen `bus_valid`, and by clearing it right after each edge. It also inserts random wait states, so the hold rule of R9 is exercised.

Request addresses stay inside the first 64 bytes. The bus model's read bytes are a fixed function of the byte address, so the expected merged read data can be computed from the address alone. The random mix covers every size, kind, lock setting and offset, and a share of the requests are compare-exchanges. Directed requests pin down the boundary crossings.

// File: rtl/msq_pkg.sv
package msq_pkg;
  // transfer kind: bit 0 = write, bit 1 = I/O space
  typedef enum logic [1:0] {
    K_MEM_RD = 2'b00,
    K_MEM_WR = 2'b01,
    K_IO_RD  = 2'b10,
    K_IO_WR  = 2'b11
  } xfer_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/msq_decode.sv
// Works out whether a request crosses its boundary, and the lanes and
// base address of each piece.
module msq_decode #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int SB = 4
) (
  input  logic [AW-1:0]                addr,
  input  logic [1:0]                   size,
  input  logic                         cx,
  output logic                         split,
  output logic [$clog2(DW/8):0]        lo_cnt,
  output logic [$clog2(DW/8):0]        hi_cnt,
  output logic [$clog2(DW/8)-1:0]      lo_off,
  output logic [$clog2(DW/8)-1:0]      hi_off,
  output logic [AW-1:0]                lo_base,
  output logic [AW-1:0]                hi_base,
  output logic [DW/8-1:0]              lo_be,
  output logic [DW/8-1:0]              hi_be
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int CW    = OFFW + 1;
  localparam int BW    = 2 * LANES;

  logic [CW-1:0] n, bnd, off_b, room;
  logic [AW-1:0] hi_a;
  logic [BW-1:0] lo_run, hi_run, lo_sh, hi_sh;

  always_comb begin
    n      = cx ? CW'(LANES) : (CW'(1) << size);
    bnd    = (n > CW'(SB)) ? CW'(LANES) : CW'(SB);
    off_b  = CW'(addr[OFFW-1:0]) & (bnd - CW'(1));
    room   = bnd - off_b;
    split  = n > room;
    lo_cnt = split ? room : n;
    hi_cnt = n - lo_cnt;
    lo_off = addr[OFFW-1:0];
    hi_a   = addr + AW'(lo_cnt);
    hi_off = hi_a[OFFW-1:0];
    lo_base = {addr[AW-1:OFFW], {OFFW{1'b0}}};
    hi_base = {hi_a[AW-1:OFFW], {OFFW{1'b0}}};
    lo_run = (BW'(1) << lo_cnt) - BW'(1);
    hi_run = (BW'(1) << hi_cnt) - BW'(1);
    lo_sh  = lo_run << lo_off;
    hi_sh  = hi_run << hi_off;
    lo_be  = lo_sh[LANES-1:0];
    hi_be  = hi_sh[LANES-1:0];
  end
endmodule

// File: rtl/msq_lane.sv
// Steers write bytes onto bus lanes, and turns read lanes back into a
// right-justified part for each piece.
module msq_lane #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           rdata,
  input  logic                    piece_hi,
  input  logic [$clog2(DW/8)-1:0] lo_off,
  input  logic [$clog2(DW/8)-1:0] hi_off,
  input  logic [$clog2(DW/8):0]   lo_cnt,
  input  logic [$clog2(DW/8):0]   hi_cnt,
  output logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           lo_part,
  output logic [DW-1:0]           hi_part
);
  localparam int LANES = DW / 8;
  localparam int CW    = $clog2(LANES) + 1;

  logic [DW-1:0] lo_mask, hi_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lo_mask[8*i +: 8] = {8{CW'(i) < lo_cnt}};
    assign hi_mask[8*i +: 8] = {8{CW'(i) < hi_cnt}};
  end

  assign bus_wdata = piece_hi ? ((wdata >> (8 * lo_cnt)) << (8 * hi_off))
                              : (wdata << (8 * lo_off));
  assign lo_part   = (rdata >> (8 * lo_off)) & lo_mask;
  assign hi_part   = ((rdata >> (8 * hi_off)) & hi_mask) << (8 * lo_cnt);
endmodule

// File: rtl/msq_ctrl.sv
// Step sequencer: chooses the piece and the direction of every bus cycle.
module msq_ctrl
  import msq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic done,
  input  logic split,
  input  logic cx,
  input  logic io_wr,
  input  logic kind_wr,
  output logic busy,
  output logic piece_hi,
  output logic is_write,
  output logic rsp_pulse
);
  seq_state_e  state;
  logic [2:0]  step;
  logic [2:0]  last_step;
  logic        at_last;

  always_comb begin
    if (cx) last_step = split ? 3'd7 : 3'd1;
    else    last_step = split ? 3'd1 : 3'd0;
    at_last = (step == last_step);
    if (cx)         piece_hi = split & step[0];
    else if (io_wr) piece_hi = split & ~step[0];
    else            piece_hi = split & step[0];
    if (cx) is_write = split ? step[2] : step[0];
    else    is_write = kind_wr;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step      <= '0;
      rsp_pulse <= 1'b0;
    end else begin
      rsp_pulse <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          step  <= '0;
        end
        ST_RUN: if (done) begin
          if (at_last) begin
            state     <= ST_IDLE;
            rsp_pulse <= 1'b1;
          end else begin
            step <= step + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import msq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int SB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic [1:0]      req_kind,
  input  logic            req_lock,
  input  logic            req_cmpx,
  input  logic [DW-1:0]   req_wdata,
  output logic            bus_valid,
  input  logic            bus_done,
  output logic [AW-1:0]   bus_addr,
  output logic [DW/8-1:0] bus_be,
  output logic            bus_write,
  output logic            bus_io,
  output logic            bus_lock,
  output logic            bus_scyc,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  // request held for the whole sequence
  logic [AW-1:0] r_addr;
  logic [1:0]    r_size;
  xfer_kind_e    r_kind;
  logic          r_lock, r_cx;
  logic [DW-1:0] r_wdata;
  logic [DW-1:0] lo_rd, hi_rd;

  logic               split;
  logic [OFFW:0]      lo_cnt, hi_cnt;
  logic [OFFW-1:0]    lo_off, hi_off;
  logic [AW-1:0]      lo_base, hi_base;
  logic [LANES-1:0]   lo_be, hi_be;
  logic [DW-1:0]      lo_part, hi_part;
  logic               busy, piece_hi, is_write, accept;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_size  <= '0;
      r_kind  <= K_MEM_RD;
      r_lock  <= 1'b0;
      r_cx    <= 1'b0;
      r_wdata <= '0;
      lo_rd   <= '0;
      hi_rd   <= '0;
    end else if (accept) begin
      r_addr  <= req_addr;
      r_size  <= req_size;
      r_kind  <= xfer_kind_e'(req_kind);
      r_lock  <= req_lock;
      r_cx    <= req_cmpx;
      r_wdata <= req_wdata;
      lo_rd   <= '0;
      hi_rd   <= '0;
    end else if (busy && bus_done && !is_write) begin
      if (piece_hi) hi_rd <= hi_part;
      else          lo_rd <= lo_part;
    end
  end

  msq_decode #(.AW(AW), .DW(DW), .SB(SB)) u_dec (
    .addr(r_addr), .size(r_size), .cx(r_cx),
    .split(split), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .lo_off(lo_off), .hi_off(hi_off),
    .lo_base(lo_base), .hi_base(hi_base),
    .lo_be(lo_be), .hi_be(hi_be)
  );

  msq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(bus_done),
    .split(split), .cx(r_cx), .io_wr(r_kind == K_IO_WR),
    .kind_wr(r_kind[0]), .busy(busy), .piece_hi(piece_hi),
    .is_write(is_write), .rsp_pulse(rsp_valid)
  );

  msq_lane #(.DW(DW)) u_lane (
    .wdata(r_wdata), .rdata(bus_rdata), .piece_hi(piece_hi),
    .lo_off(lo_off), .hi_off(hi_off), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .bus_wdata(bus_wdata), .lo_part(lo_part), .hi_part(hi_part)
  );

  assign bus_valid = busy;
  assign bus_addr  = piece_hi ? hi_base : lo_base;
  assign bus_be    = piece_hi ? hi_be : lo_be;
  assign bus_write = is_write;
  assign bus_io    = r_kind[1] & ~r_cx;
  assign bus_lock  = r_lock | r_cx;
  assign bus_scyc  = (r_lock | r_cx) & split;
  assign rsp_rdata = lo_rd | hi_rd;
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            bus_valid,
  input logic            bus_done,
  input logic [AW-1:0]   bus_addr,
  input logic [DW/8-1:0] bus_be,
  input logic            bus_write,
  input logic            bus_lock,
  input logic            bus_scyc,
  input logic [DW-1:0]   bus_wdata,
  input logic            rsp_valid
);
  localparam int OFFW = $clog2(DW / 8);

  // R9
  hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
      && $stable(bus_write) && $stable(bus_lock) && $stable(bus_wdata));

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R3
  qword_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[OFFW-1:0] == '0) && (bus_be != '0));

  // R5
  scyc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_scyc |-> bus_lock);

  // R8
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bus_valid && bus_done));
endmodule

bind xfer_splitter xfer_splitter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_valid(bus_valid),
  .bus_done(bus_done), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_write(bus_write), .bus_lock(bus_lock), .bus_scyc(bus_scyc),
  .bus_wdata(bus_wdata), .rsp_valid(rsp_valid)
);

// File: tb/tb_xfer_splitter.sv
`timescale 1ns/1ps
module tb_xfer_splitter;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [1:0] req_kind = '0;
  logic req_lock = 1'b0;
  logic req_cmpx = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic bus_valid;
  logic bus_done = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_be;
  logic bus_write, bus_io, bus_lock, bus_scyc;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_splitter #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // log of observed completed bus cycles
  logic [AW-1:0] l_addr [8];
  logic [7:0]    l_be   [8];
  logic          l_wr   [8], l_io [8], l_lk [8], l_sc [8];
  logic [63:0]   l_wd   [8];

  task automatic run_req(int a, int sz, int kind, bit lk, bit cx,
                         logic [63:0] wd, string nm);
    int n, bnd, room, lc, ne, nl;
    bit sp, got, any_rd;
    int ps [8];
    int pc [8];
    bit ew [8];
    logic [63:0] rd, exp_rd;
    n = cx ? 8 : (1 << sz);
    bnd = (n > 4) ? 8 : 4;
    room = bnd - (a % bnd);
    sp = n > room;
    lc = sp ? room : n;
    // expected sequence (R1 R2 R4 R6)
    if (cx && sp) begin
      ne = 8;
      for (int s = 0; s < 8; s++) begin
        ps[s] = (s % 2) ? a + lc : a;
        pc[s] = (s % 2) ? n - lc : lc;
        ew[s] = (s >= 4);
      end
    end else if (cx) begin
      ne = 2;
      ps[0] = a; pc[0] = n; ew[0] = 0;
      ps[1] = a; pc[1] = n; ew[1] = 1;
    end else if (sp) begin
      ne = 2;
      if (kind == 3) begin
        ps[0] = a + lc; pc[0] = n - lc; ps[1] = a; pc[1] = lc;
      end else begin
        ps[0] = a; pc[0] = lc; ps[1] = a + lc; pc[1] = n - lc;
      end
      ew[0] = kind[0]; ew[1] = kind[0];
    end else begin
      ne = 1; ps[0] = a; pc[0] = n; ew[0] = kind[0];
    end
    any_rd = 0;
    for (int s = 0; s < ne; s++) if (!ew[s]) any_rd = 1;
    exp_rd = '0;
    if (any_rd) for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = pat(a + i);

    req_addr = AW'(a); req_size = 2'(sz); req_kind = 2'(kind);
    req_lock = lk; req_cmpx = cx; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    got = 0; nl = 0; rd = '0;
    for (int g = 0; g < 60 && !got; g++) begin
      if (rsp_valid) begin
        got = 1; rd = rsp_rdata;
      end else if (bus_valid) begin
        chk(req_ready == 1'b0, {nm, " R9 ready low while busy"}, 64'(req_ready), 64'd0);
        for (int k = 0; k < 8; k++) bus_rdata[8*k +: 8] = pat(int'(bus_addr) + k);
        if ($urandom % 4 != 0) begin
          if (nl < 8) begin
            l_addr[nl] = bus_addr; l_be[nl] = bus_be; l_wr[nl] = bus_write;
            l_io[nl] = bus_io; l_lk[nl] = bus_lock; l_sc[nl] = bus_scyc;
            l_wd[nl] = bus_wdata;
          end
          nl++;
          bus_done = 1'b1;
        end
      end
      if (!got) begin
        @(posedge clk); #1;
        bus_done = 1'b0;
      end
    end
    chk(got, {nm, " R8 response pulse"}, 64'(got), 64'd1);
    chk(nl == ne, {nm, " R1 R2 R6 bus cycle count"}, 64'(nl), 64'(ne));
    for (int s = 0; s < ne && s < nl; s++) begin
      logic [7:0] ebe;
      logic [AW-1:0] eaddr;
      ebe = '0;
      for (int i = 0; i < pc[s]; i++) ebe[(ps[s] + i) % 8] = 1'b1;
      eaddr = AW'(ps[s] & ~7);
      chk(l_addr[s] == eaddr && l_be[s] == ebe, {nm, " R3 R4 address and enables"},
          {l_addr[s], 24'd0, l_be[s]}, {eaddr, 24'd0, ebe});
      chk(l_wr[s] == ew[s], {nm, " R4 R6 direction"}, 64'(l_wr[s]), 64'(ew[s]));
      chk(l_lk[s] == (lk | cx) && l_sc[s] == ((lk | cx) & sp),
          {nm, " R5 lock and scyc"}, {62'd0, l_lk[s], l_sc[s]},
          {62'd0, lk | cx, (lk | cx) & sp});
      chk(l_io[s] == (kind[1] & !cx), {nm, " R4 io space"}, 64'(l_io[s]), 64'(kind[1] & !cx));
      if (ew[s]) begin
        for (int k = 0; k < 8; k++) if (l_be[s][k]) begin
          int idx;
          idx = int'(l_addr[s]) + k - a;
          chk(l_wd[s][8*k +: 8] == wd[8*idx +: 8], {nm, " R7 write lane"},
              64'(l_wd[s][8*k +: 8]), 64'(wd[8*idx +: 8]));
        end
      end
    end
    chk(rd == exp_rd, {nm, " R8 merged read data"}, rd, exp_rd);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R10
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && rsp_valid == 1'b0,
        "R10 reset state", {61'd0, req_ready, bus_valid, rsp_valid}, 64'd4);
    run_req(7,  2, 0, 0, 0, 64'h1122334455667788, "R2 dword at 7");
    run_req(1,  1, 0, 0, 0, 64'h0000_0000_0000_a5b6, "R1 word at 1");
    run_req(3,  1, 1, 0, 0, 64'h0000_0000_0000_c3d4, "R2 word at 3");
    run_req(2,  2, 0, 0, 0, 64'h0, "R3 dword at 2 same quad");
    run_req(6,  2, 3, 0, 0, 64'h0000_0000_deadbeef, "R4 io write at 6");
    run_req(6,  2, 2, 0, 0, 64'h0, "R4 io read at 6");
    run_req(12, 3, 0, 0, 0, 64'h0, "R2 qword at 12");
    run_req(16, 3, 1, 0, 0, 64'h0102030405060708, "R2 qword aligned");
    run_req(5,  2, 1, 1, 0, 64'h0000_0000_cafef00d, "R5 locked split");
    run_req(8,  2, 1, 1, 0, 64'h0000_0000_0badf00d, "R5 locked aligned");
    run_req(13, 0, 2, 0, 0, 64'h0, "R1 byte");
    run_req(12, 3, 1, 0, 1, 64'h8877665544332211, "R6 cmpx misaligned");
    run_req(24, 0, 2, 0, 1, 64'hfedcba9876543210, "R6 cmpx aligned");
    for (int t = 0; t < 300; t++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      run_req(int'($urandom % 56), int'($urandom % 4), int'($urandom % 4),
              bit'($urandom % 2), ($urandom % 8) == 0, w, "random");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule